// File: doc/BRIEF.md
# RTC interrupt flag controller

This block owns the second control register of a real-time clock and drives its single active-low interrupt pin. Upstream counters supply one-cycle strobes for a seconds tick, a minutes tick, an alarm match and a countdown expiry. They also supply a level that says whether the oscillator is running. The block turns these strobes into sticky flags, gates them with enable bits, and drives the pin either as a level or as a fixed-width pulse.

Software reaches the block through a simple synchronous write port and a combinational read port. The control register sits at address 01h. A second address, 02h by default, exposes the oscillator-stop flag in bit 7. Event flags are set only by hardware. They are cleared by writing 0 to the flag bit. Writing 1 to a flag bit leaves it as it is, so a read-modify-write sequence cannot drop an event.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, the register at 01h reads 00h, the register at 02h reads 80h (oscillator-stop flag set), and irq_no is 1.
- R2: A write to 01h loads the enable and mode bits: bit 7 minute enable, bit 6 second enable, bit 4 pulse mode, bit 1 alarm enable, bit 0 countdown enable. These bits read back unchanged.
- R3: Bit 5 of 01h is set one cycle after a minute tick while bit 7 is 1, or after a second tick while bit 6 is 1. A tick whose enable is 0 leaves bit 5 unchanged.
- R4: Bit 3 of 01h is set after an alarm strobe, and bit 2 is set after a countdown strobe, whatever the enable bits hold.
- R5: Writing 0 to flag bit 5, 3 or 2 of 01h clears that flag. Writing 1 leaves it unchanged and never sets it.
- R6: When an event strobe and a clearing write to the same flag fall in the same cycle, the flag ends up set.
- R7: With bit 4 at 0, irq_no is 0 exactly when bit 5 is set, or bit 3 and bit 1 are both set, or bit 2 and bit 0 are both set.
- R8: With bit 4 at 1, an enabled minute or second event, or a countdown strobe while bit 0 is 1, drives irq_no low for PULSE_LEN cycles starting in the next cycle. A new event reloads the width, and flags 5 and 2 do not hold the pin.
- R9: With bit 4 at 1, irq_no is held low for as long as bit 3 and bit 1 are both set.
- R10: Bit 7 at 02h is set one cycle after osc_run_i is 0 in any cycle. Writing 0 to it clears it only while osc_run_i is 1.
- R11: Writes to any address other than 01h and 02h have no effect, and such addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| sec_tick_i | input | 1 | Seconds tick strobe |
| min_tick_i | input | 1 | Minutes tick strobe |
| alarm_i | input | 1 | Alarm match strobe |
| timer_i | input | 1 | Countdown expiry strobe |
| osc_run_i | input | 1 | Oscillator running indication |
| irq_no | output | 1 | Interrupt pin, active low |

## Verification
The assertions assume that every input is already synchronous to clk_i and never X. This includes osc_run_i, which an upstream stage must synchronize. Strobes may be held for several cycles or may coincide with writes. The bench drives all inputs one half-period away from the active edge, so they are stable and synchronous. It mixes strobe collisions, writes that clear flags, and oscillator dropouts freely, without leaving these assumptions.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int B_MIN_EN = 7;
  localparam int B_SEC_EN = 6;
  localparam int B_MSF    = 5;
  localparam int B_PULSE  = 4;
  localparam int B_AF     = 3;
  localparam int B_TF     = 2;
  localparam int B_AIE    = 1;
  localparam int B_TIE    = 0;
  localparam int B_OSF    = 7;

  localparam int NFLG   = 4;
  localparam int FLG_MS = 0;
  localparam int FLG_AL = 1;
  localparam int FLG_TM = 2;
  localparam int FLG_OS = 3;

  typedef struct packed {
    logic min_en;
    logic sec_en;
    logic pulse_md;
    logic aie;
    logic tie;
  } ctrl_en_t;
endpackage

// File: rtl/rtc_sticky_flag.sv
module rtc_sticky_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= RST_VAL;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/rtc_irq_pulse.sv
module rtc_irq_pulse #(
  parameter int PULSE_LEN = 4,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (trig_i)          cnt_o <= CNT_W'(PULSE_LEN);
    else if (cnt_o != '0)     cnt_o <= cnt_o - 1'b1;
  end

  assign active_o = (cnt_o != '0);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PULSE_LEN = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] OSC_ADDR  = 'h2,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              sec_tick_i,
  input  logic              min_tick_i,
  input  logic              alarm_i,
  input  logic              timer_i,
  input  logic              osc_run_i,
  output logic              irq_no
);
  ctrl_en_t         en_q;
  logic             wr_ctrl, wr_osc, ms_evt, pulse_trig, pulse_act;
  logic             alarm_irq, level_irq;
  logic [NFLG-1:0]  flg_set, flg_clr, flg_q;
  logic             msf_q, af_q, tf_q, osf_q;
  logic [CNT_W-1:0] pulse_cnt;
  logic [7:0]       ctrl_rd;

  assign wr_ctrl = wr_en_i && (addr_i == CTRL_ADDR);
  assign wr_osc  = wr_en_i && (addr_i == OSC_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (wr_ctrl) begin
      en_q.min_en   <= wdata_i[B_MIN_EN];
      en_q.sec_en   <= wdata_i[B_SEC_EN];
      en_q.pulse_md <= wdata_i[B_PULSE];
      en_q.aie      <= wdata_i[B_AIE];
      en_q.tie      <= wdata_i[B_TIE];
    end
  end

  assign ms_evt = (min_tick_i & en_q.min_en) | (sec_tick_i & en_q.sec_en);

  always_comb begin
    flg_set         = '0;
    flg_clr         = '0;
    flg_set[FLG_MS] = ms_evt;
    flg_set[FLG_AL] = alarm_i;
    flg_set[FLG_TM] = timer_i;
    flg_set[FLG_OS] = ~osc_run_i;
    flg_clr[FLG_MS] = wr_ctrl & ~wdata_i[B_MSF];
    flg_clr[FLG_AL] = wr_ctrl & ~wdata_i[B_AF];
    flg_clr[FLG_TM] = wr_ctrl & ~wdata_i[B_TF];
    flg_clr[FLG_OS] = wr_osc  & ~wdata_i[B_OSF];
  end

  for (genvar g = 0; g < NFLG; g++) begin : g_flg
    rtc_sticky_flag #(
      .RST_VAL((g == FLG_OS) ? 1'b1 : 1'b0)
    ) u_flg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flg_set[g]),
      .clr_i  (flg_clr[g]),
      .flag_o (flg_q[g])
    );
  end

  assign msf_q = flg_q[FLG_MS];
  assign af_q  = flg_q[FLG_AL];
  assign tf_q  = flg_q[FLG_TM];
  assign osf_q = flg_q[FLG_OS];

  assign pulse_trig = ms_evt | (timer_i & en_q.tie);

  rtc_irq_pulse #(
    .PULSE_LEN(PULSE_LEN)
  ) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (pulse_trig),
    .cnt_o    (pulse_cnt),
    .active_o (pulse_act)
  );

  assign alarm_irq = af_q & en_q.aie;
  assign level_irq = msf_q | alarm_irq | (tf_q & en_q.tie);
  assign irq_no    = ~(en_q.pulse_md ? (pulse_act | alarm_irq) : level_irq);

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[B_MIN_EN] = en_q.min_en;
    ctrl_rd[B_SEC_EN] = en_q.sec_en;
    ctrl_rd[B_MSF]    = msf_q;
    ctrl_rd[B_PULSE]  = en_q.pulse_md;
    ctrl_rd[B_AF]     = af_q;
    ctrl_rd[B_TF]     = tf_q;
    ctrl_rd[B_AIE]    = en_q.aie;
    ctrl_rd[B_TIE]    = en_q.tie;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR)     rdata_o = ctrl_rd;
    else if (addr_i == OSC_ADDR) rdata_o[B_OSF] = osf_q;
  end
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int PULSE_LEN = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] OSC_ADDR  = 'h2,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              sec_tick_i,
  input logic              min_tick_i,
  input logic              alarm_i,
  input logic              timer_i,
  input logic              osc_run_i,
  input logic              irq_no,
  input logic              msf_q,
  input logic              af_q,
  input logic              tf_q,
  input logic              osf_q,
  input logic              sec_en,
  input logic              min_en,
  input logic              pulse_md,
  input logic              aie,
  input logic              tie,
  input logic [CNT_W-1:0]  pulse_cnt
);
  assert_sec_sets_msf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && sec_en) |=> msf_q);
  assert_min_sets_msf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_tick_i && min_en) |=> msf_q);
  assert_alarm_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i |=> af_q);
  assert_timer_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_i |=> tf_q);
  assert_msf_clear_by_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(msf_q) |-> $past(wr_en_i && addr_i == CTRL_ADDR));
  assert_af_clear_by_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(af_q) |-> $past(wr_en_i && addr_i == CTRL_ADDR));
  assert_tf_clear_by_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tf_q) |-> $past(wr_en_i && addr_i == CTRL_ADDR));
  assert_level_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_md && (msf_q || (tf_q && tie))) |-> !irq_no);
  assert_pulse_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_cnt <= CNT_W'(PULSE_LEN));
  assert_pulse_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_i && tie) |=> (pulse_cnt == CNT_W'(PULSE_LEN)));
  assert_alarm_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (af_q && aie) |-> !irq_no);
  assert_osc_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_run_i |=> osf_q);
  assert_osc_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osf_q) |-> $past(osc_run_i && wr_en_i && addr_i == OSC_ADDR && !wdata_i[7]));
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN), .CTRL_ADDR(CTRL_ADDR), .OSC_ADDR(OSC_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .sec_tick_i(sec_tick_i), .min_tick_i(min_tick_i), .alarm_i(alarm_i), .timer_i(timer_i),
  .osc_run_i(osc_run_i), .irq_no(irq_no), .msf_q(msf_q), .af_q(af_q), .tf_q(tf_q),
  .osf_q(osf_q), .sec_en(en_q.sec_en), .min_en(en_q.min_en), .pulse_md(en_q.pulse_md),
  .aie(en_q.aie), .tie(en_q.tie), .pulse_cnt(pulse_cnt)
);

// File: tb/rtc_irq_ctrl_bench.sv
module rtc_irq_ctrl_bench;
  localparam int PL = 4;
  localparam logic [3:0] A_CTRL = 4'h1;
  localparam logic [3:0] A_OSC  = 4'h2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sec_t = 1'b0, min_t = 1'b0, alarm = 1'b0, timer = 1'b0, osc_run = 1'b1;
  logic       irq_n;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_ctrl;
  logic       m_osf;
  int         m_cnt;

  always #10 clk = ~clk;

  rtc_irq_ctrl #(.ADDR_W(4), .PULSE_LEN(PL)) u_rtc_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sec_tick_i(sec_t), .min_tick_i(min_t), .alarm_i(alarm),
    .timer_i(timer), .osc_run_i(osc_run), .irq_no(irq_n)
  );

  function automatic logic exp_irq_n();
    if (m_ctrl[4]) return !((m_cnt != 0) || (m_ctrl[3] && m_ctrl[1]));
    return !(m_ctrl[5] || (m_ctrl[3] && m_ctrl[1]) || (m_ctrl[2] && m_ctrl[0]));
  endfunction

  function automatic logic [7:0] next_ctrl(logic wr, logic [3:0] a, logic [7:0] wd,
                                           logic sec, logic mn, logic al, logic tm);
    logic [7:0] n;
    logic ms;
    ms = (mn && m_ctrl[7]) || (sec && m_ctrl[6]);
    n = m_ctrl;
    if (wr && a == A_CTRL) begin
      n[7] = wd[7]; n[6] = wd[6]; n[4] = wd[4]; n[1] = wd[1]; n[0] = wd[0];
      n[5] = m_ctrl[5] & wd[5]; n[3] = m_ctrl[3] & wd[3]; n[2] = m_ctrl[2] & wd[2];
    end
    n[5] = n[5] | ms;
    n[3] = n[3] | al;
    n[2] = n[2] | tm;
    return n;
  endfunction

  task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(logic [3:0] a, logic [7:0] exp, string tag);
    addr = a;
    #1;
    check(rdata, exp, tag);
  endtask

  task automatic step(logic wr, logic [3:0] a, logic [7:0] wd, logic sec, logic mn,
                      logic al, logic tm, logic run);
    logic ms, trig;
    wr_en = wr; addr = a; wdata = wd;
    sec_t = sec; min_t = mn; alarm = al; timer = tm; osc_run = run;
    @(posedge clk);
    ms   = (mn && m_ctrl[7]) || (sec && m_ctrl[6]);
    trig = ms || (tm && m_ctrl[0]);
    m_ctrl = next_ctrl(wr, a, wd, sec, mn, al, tm);
    if (trig)           m_cnt = PL;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    if (!run)                                 m_osf = 1'b1;
    else if (wr && a == A_OSC && !wd[7])      m_osf = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; sec_t = 1'b0; min_t = 1'b0; alarm = 1'b0; timer = 1'b0;
    check({7'b0, irq_n}, {7'b0, exp_irq_n()}, m_ctrl[4] ? "R8 pulse-mode pin" : "R7 level-mode pin");
    rd_chk(A_CTRL, m_ctrl, "R3 control register");
    rd_chk(A_OSC, {m_osf, 7'b0}, "R10 oscillator flag");
  endtask

  task automatic idle();
    step(1'b0, A_CTRL, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    m_ctrl = 8'h00; m_osf = 1'b1; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk(A_CTRL, 8'h00, "R1 ctrl reset");
    rd_chk(A_OSC, 8'h80, "R1 osc reset");
    check({7'b0, irq_n}, 8'h01, "R1 pin reset");

    // R2 enables read back
    wr(A_CTRL, 8'hD3);
    rd_chk(A_CTRL, 8'hD3, "R2 enable readback");
    wr(A_CTRL, 8'h00);

    // R3 masked ticks, then enabled ticks
    step(1'b0, A_CTRL, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    rd_chk(A_CTRL, 8'h00, "R3 masked ticks");
    wr(A_CTRL, 8'h40);
    step(1'b0, A_CTRL, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    rd_chk(A_CTRL, 8'h60, "R3 second tick");
    check({7'b0, irq_n}, 8'h00, "R7 msf drives pin");
    wr(A_CTRL, 8'h60);
    rd_chk(A_CTRL, 8'h60, "R5 write one keeps msf");
    wr(A_CTRL, 8'h40);
    rd_chk(A_CTRL, 8'h40, "R5 write zero clears msf");
    step(1'b0, A_CTRL, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    rd_chk(A_CTRL, 8'h40, "R3 minute tick masked");
    wr(A_CTRL, 8'h80);
    step(1'b0, A_CTRL, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    rd_chk(A_CTRL, 8'hA0, "R3 minute tick");
    wr(A_CTRL, 8'h00);

    // R4 alarm and countdown flags without enables
    step(1'b0, A_CTRL, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, A_CTRL, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    rd_chk(A_CTRL, 8'h0C, "R4 alarm and countdown flags");
    check({7'b0, irq_n}, 8'h01, "R7 disabled flags keep pin high");
    wr(A_CTRL, 8'h0F);
    check({7'b0, irq_n}, 8'h00, "R7 enabled flags pull pin");
    wr(A_CTRL, 8'h00);
    rd_chk(A_CTRL, 8'h00, "R5 flags cleared");
    check({7'b0, irq_n}, 8'h01, "R7 pin released");

    // R6 event beats clear
    step(1'b1, A_CTRL, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    rd_chk(A_CTRL, 8'h08, "R6 alarm wins over clear");
    wr(A_CTRL, 8'h00);

    // R11 unmapped address
    wr(4'h5, 8'hFF);
    rd_chk(4'h5, 8'h00, "R11 unmapped read");
    rd_chk(A_CTRL, 8'h00, "R11 unmapped write ignored");

    // R10 oscillator flag
    wr(A_OSC, 8'h00);
    rd_chk(A_OSC, 8'h00, "R10 clear while running");
    step(1'b0, A_CTRL, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rd_chk(A_OSC, 8'h80, "R10 set on stop");
    step(1'b1, A_OSC, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rd_chk(A_OSC, 8'h80, "R10 clear ignored while stopped");
    wr(A_OSC, 8'h00);
    rd_chk(A_OSC, 8'h00, "R10 clear after restart");

    // R8 pulse width from countdown event
    wr(A_CTRL, 8'h11);
    step(1'b0, A_CTRL, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check({7'b0, irq_n}, 8'h00, "R8 pulse start");
    for (int i = 1; i < PL + 2; i++) begin
      idle();
      check({7'b0, irq_n}, (i < PL) ? 8'h00 : 8'h01, "R8 pulse width");
    end
    rd_chk(A_CTRL, 8'h15, "R8 countdown flag still set");
    wr(A_CTRL, 8'h11);

    // R9 alarm holds pin in pulse mode
    wr(A_CTRL, 8'h12);
    step(1'b0, A_CTRL, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < PL + 2; i++) begin
      idle();
      check({7'b0, irq_n}, 8'h00, "R9 alarm holds pin");
    end
    wr(A_CTRL, 8'h12);
    check({7'b0, irq_n}, 8'h01, "R9 pin released on clear");
    wr(A_CTRL, 8'h00);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      a = ($urandom % 5 == 0) ? 4'($urandom) : (($urandom % 2 == 0) ? A_CTRL : A_OSC);
      step(($urandom % 6) == 0, a, 8'($urandom), ($urandom % 4) == 0, ($urandom % 16) == 0,
           ($urandom % 40) == 0, ($urandom % 16) == 0, ($urandom % 25) != 0);
    end

    summary();
    $finish;
  end
endmodule